// File: doc/BRIEF.md
# Address-Folded SECDED Memory Guard

This block sits between a requester and a 128-bit on-chip RAM and protects every stored word with a nine-bit single-error-correcting, double-error-detecting code. The code is computed over the data word together with the word address. The address bits are never stored. They are folded back in from the address of each read, so a word fetched from the wrong row shows up as a coding fault and is never accepted as good data.

A request carries a write flag, a word address, 128 data bits and sixteen byte enables. A read returns its response one cycle after acceptance. A single-bit fault in data or check bits is corrected. A double fault returns the raw data with an uncorrectable flag. A fault whose syndrome names an address position returns the raw data with an address-error flag. A full-width write is encoded and stored at once. A narrower write reads the old word, checks and corrects it, merges the new bytes, re-encodes and writes. It is abandoned if the old word cannot be trusted. An enable input switches protection off: words are then stored with an all-zero check field, and reads return raw data with no flags.

Top module: `ecc_mem_guard`

## Requirements
- R1: While reset is held, req_ready is 1, rsp_valid is 0 and ram_en is 0.
- R2: A full write (all 16 byte enables set) is written to RAM in its acceptance cycle and answered one cycle later with no error flag. A read of a clean word returns the written data one cycle after acceptance with no flag.
- R3: A single inverted bit anywhere in the 128 stored data bits (RAM word bits 127:0) is corrected on read, with rsp_err_corr set.
- R4: A single inverted bit in the 9-bit check field (RAM word bits 136:128) leaves the returned data intact and sets rsp_err_corr. No response ever carries more than one error flag.
- R5: When the RAM returns the word stored at an address differing from the requested one in exactly one bit, the response sets rsp_err_addr and returns that word's data uncorrected.
- R6: Two inverted bits in a stored word set rsp_err_uncorr, with the raw stored data returned in the same cycle as rsp_valid.
- R7: A write with some byte enables clear first reads the word, then writes it two cycles after acceptance and responds then. Byte i (bits 8i+7:8i) takes the new data where enable bit i is 1 and keeps the old data elsewhere. A later read of the word is clean.
- R8: If the read phase of a partial write finds an uncorrectable word, no RAM write takes place. The write response comes one cycle after acceptance with rsp_err_uncorr set, and the stored word is left unchanged.
- R9: If the read phase of a partial write finds a single-bit fault, the merge uses the corrected old data. The write response carries rsp_err_corr, and the stored result reads back clean.
- R10: With ecc_en low when a request is accepted, writes store an all-zero check field, and reads return raw stored data with all error flags clear.
- R11: Each request receives exactly one single-cycle rsp_valid pulse, and req_ready stays low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en | input | 1 | Protection enable, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| rsp_valid | output | 1 | Response pulse |
| rsp_is_write | output | 1 | Response belongs to a write |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err_corr | output | 1 | Single fault corrected |
| rsp_err_uncorr | output | 1 | Uncorrectable fault |
| rsp_err_addr | output | 1 | Address fault detected |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W+9 | Check field over data, to RAM |
| ram_rdata | input | DATA_W+9 | RAM read word, one cycle after the strobe |

## Verification
Assertions watch, on every cycle, that responses are one-cycle pulses and carry at most one flag. They also check that a read never changes more than one bit relative to the RAM word, and that flagged reads return the RAM word untouched. Further checks cover that a partial write always reads before it writes, and that any RAM write leads to a clean response. Whether a given fault is classified correctly can only be shown by the bench's scenarios. These cover each of the 128 data and 9 check positions, every one-bit address slip, paired faults, every byte-enable lane, aborted and corrected merges, and bypass mode.

// File: rtl/ecc_guard_pkg.sv
// Package ecc_guard_pkg
// Shared elaboration-time helpers for the address-folded SECDED guard.
// Assumes a Hamming layout where message bits fill the non-power-of-two
// positions from 3 upward: data bits first, then address bits.
package ecc_guard_pkg;

    localparam int MAX_MSG = 256;

    // Number of Hamming parity bits needed for a message of msg_w bits
    function automatic int ham_bits(input int msg_w);
        int r;
        r = 1;
        while ((1 << r) < (msg_w + r + 1)) r++;
        return r;
    endfunction

    // Codeword position of message bit k
    function automatic int msg_pos(input int k);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 3; p < 2 * MAX_MSG + 16; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Mask of message bits that parity bit j covers
    function automatic logic [MAX_MSG-1:0] cover_mask(input int j);
        logic [MAX_MSG-1:0] m;
        int cnt;
        m = '0;
        cnt = 0;
        for (int p = 3; p < 2 * MAX_MSG + 16; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt < MAX_MSG && ((p >> j) & 1) == 1) m[cnt] = 1'b1;
                cnt++;
            end
        end
        return m;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_RMW_RD  = 2'd2,
        ST_WR_RESP = 2'd3
    } guard_state_e;

endpackage

// File: rtl/ecc_chk_enc.sv
// Module ecc_chk_enc
// Computes the check field over {address, data}: HAM_W Hamming parity
// bits plus one overall parity bit (MSB) covering message and parity.
// Purely combinational; assumes DATA_W + ADDR_W fits the package limit.
module ecc_chk_enc
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0]                       data,
    input  logic [ADDR_W-1:0]                       addr,
    output logic [ham_bits(DATA_W+ADDR_W):0]        chk
);
    localparam int MSG_W = DATA_W + ADDR_W;
    localparam int HAM_W = ham_bits(MSG_W);

    logic [MSG_W-1:0] msg;
    logic [HAM_W-1:0] ham;

    // Message order: data in low bits, address above it
    assign msg = {addr, data};

    // One parity tree per Hamming bit over the positions it covers
    for (genvar j = 0; j < HAM_W; j++) begin : g_par
        localparam logic [MAX_MSG-1:0] MASK = cover_mask(j);
        assign ham[j] = ^(msg & MASK[MSG_W-1:0]);
    end

    // Overall parity extends distance to four
    assign chk = {(^msg) ^ (^ham), ham};

endmodule

// File: rtl/ecc_syn_dec.sv
// Module ecc_syn_dec
// Recomputes the check field from the read data and the requested
// address, forms the syndrome and classifies the word: clean, single
// fault in data/check (corrected), single fault at an address position
// (address error, not corrected), or uncorrectable.
// Combinational; the caller gates results when protection is off.
module ecc_syn_dec
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0]                   rd_data,
    input  logic [ham_bits(DATA_W+ADDR_W):0]    rd_chk,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   fix_data,
    output logic                                is_corr,
    output logic                                is_uncorr,
    output logic                                is_aerr
);
    localparam int MSG_W = DATA_W + ADDR_W;
    localparam int HAM_W = ham_bits(MSG_W);

    logic [HAM_W:0]    calc;
    logic [HAM_W-1:0]  syn;
    logic              par_bad;
    logic [DATA_W-1:0] hit_d;
    logic [ADDR_W-1:0] hit_a;
    logic              syn_zero, syn_chk, any_d, any_a;

    ecc_chk_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_recalc (
        .data (rd_data),
        .addr (rd_addr),
        .chk  (calc)
    );

    // Syndrome and overall parity mismatch
    assign syn     = calc[HAM_W-1:0] ^ rd_chk[HAM_W-1:0];
    assign par_bad = calc[HAM_W] ^ rd_chk[HAM_W] ^ (^syn);

    // Position match for every data bit
    for (genvar k = 0; k < DATA_W; k++) begin : g_hit_d
        localparam logic [HAM_W-1:0] POS = HAM_W'(msg_pos(k));
        assign hit_d[k] = (syn == POS);
    end

    // Position match for every folded address bit
    for (genvar a = 0; a < ADDR_W; a++) begin : g_hit_a
        localparam logic [HAM_W-1:0] POS = HAM_W'(msg_pos(DATA_W + a));
        assign hit_a[a] = (syn == POS);
    end

    assign syn_zero = (syn == '0);
    assign syn_chk  = $onehot(syn);
    assign any_d    = |hit_d;
    assign any_a    = |hit_a;

    // Classification of the syndrome
    assign is_corr   = par_bad && (syn_zero || syn_chk || any_d);
    assign is_aerr   = par_bad && any_a;
    assign is_uncorr = (!par_bad && !syn_zero) ||
                       (par_bad && !syn_zero && !syn_chk && !any_d && !any_a);

    // Flip the named data bit only for a single fault
    assign fix_data = rd_data ^ (par_bad ? hit_d : '0);

endmodule

// File: rtl/ecc_rmw_seq.sv
// Module ecc_rmw_seq
// Request sequencer: accepts one request at a time, issues RAM reads and
// writes, runs the read-merge-write flow for partial writes, and forms
// the single-cycle response. Assumes a RAM with one cycle read latency.
module ecc_rmw_seq
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ecc_en,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W/8-1:0]     req_be,
    input  logic [DATA_W-1:0]       raw_data,
    input  logic [DATA_W-1:0]       dec_fix,
    input  logic                    dec_corr,
    input  logic                    dec_uncorr,
    input  logic                    dec_aerr,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic                    ram_en,
    output logic                    ram_we,
    output logic [ADDR_W-1:0]       ram_addr,
    output logic [DATA_W-1:0]       enc_data,
    output logic [ADDR_W-1:0]       enc_addr,
    output logic                    enc_on,
    output logic                    rsp_valid,
    output logic                    rsp_is_write,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    rsp_err_corr,
    output logic                    rsp_err_uncorr,
    output logic                    rsp_err_addr
);
    localparam int BE_W = DATA_W / 8;

    guard_state_e      state, state_d;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [BE_W-1:0]   rq_be;
    logic              rq_en;
    logic              wr_corr_q;
    logic [DATA_W-1:0] base, merged;
    logic              accept, abort;

    assign accept   = req_valid && (state == ST_IDLE);
    assign cur_addr = rq_addr;

    // Old word for merging: corrected when protection is on
    assign base  = rq_en ? dec_fix : raw_data;
    assign abort = rq_en && (dec_uncorr || dec_aerr);

    // Byte-lane merge of new data over the old word
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign merged[8*i +: 8] = rq_be[i] ? rq_wdata[8*i +: 8] : base[8*i +: 8];
    end

    // Capture the request and advance the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rq_addr   <= '0;
            rq_wdata  <= '0;
            rq_be     <= '0;
            rq_en     <= 1'b0;
            wr_corr_q <= 1'b0;
        end else begin
            state <= state_d;
            if (accept) begin
                rq_addr   <= req_addr;
                rq_wdata  <= req_wdata;
                rq_be     <= req_be;
                rq_en     <= ecc_en;
                wr_corr_q <= 1'b0;
            end else if (state == ST_RMW_RD) begin
                wr_corr_q <= rq_en && dec_corr;
            end
        end
    end

    // RAM commands, encoder inputs and response per state
    always_comb begin
        state_d        = state;
        req_ready      = 1'b0;
        ram_en         = 1'b0;
        ram_we         = 1'b0;
        ram_addr       = req_addr;
        enc_data       = req_wdata;
        enc_addr       = req_addr;
        enc_on         = ecc_en;
        rsp_valid      = 1'b0;
        rsp_is_write   = 1'b0;
        rsp_rdata      = '0;
        rsp_err_corr   = 1'b0;
        rsp_err_uncorr = 1'b0;
        rsp_err_addr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ram_en = 1'b1;
                    if (req_write && (&req_be)) begin
                        ram_we  = 1'b1;
                        state_d = ST_WR_RESP;
                    end else if (req_write) begin
                        state_d = ST_RMW_RD;
                    end else begin
                        state_d = ST_RD_RESP;
                    end
                end
            end
            ST_RD_RESP: begin
                rsp_valid      = 1'b1;
                rsp_rdata      = base;
                rsp_err_corr   = rq_en && dec_corr;
                rsp_err_uncorr = rq_en && dec_uncorr;
                rsp_err_addr   = rq_en && dec_aerr;
                state_d        = ST_IDLE;
            end
            ST_RMW_RD: begin
                if (abort) begin
                    rsp_valid      = 1'b1;
                    rsp_is_write   = 1'b1;
                    rsp_err_uncorr = dec_uncorr;
                    rsp_err_addr   = dec_aerr;
                    state_d        = ST_IDLE;
                end else begin
                    ram_en   = 1'b1;
                    ram_we   = 1'b1;
                    ram_addr = rq_addr;
                    enc_data = merged;
                    enc_addr = rq_addr;
                    enc_on   = rq_en;
                    state_d  = ST_WR_RESP;
                end
            end
            ST_WR_RESP: begin
                rsp_valid    = 1'b1;
                rsp_is_write = 1'b1;
                rsp_err_corr = wr_corr_q;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R7: a partial write must begin with a RAM read, never a write
    a_r7_rmw_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !(&req_be)) |-> (ram_en && !ram_we));

    // R8: any RAM write is followed by a response without abort flags
    a_r8_write_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we) |=> (rsp_valid && rsp_is_write && !rsp_err_uncorr && !rsp_err_addr));

endmodule

// File: rtl/ecc_mem_guard.sv
// Module ecc_mem_guard (top)
// Address-folded SECDED guard between a requester and a 128-bit RAM.
// Stores {check, data} words; the address is folded into the code but
// not stored. Assumes a single-port RAM with one cycle read latency.
module ecc_mem_guard
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 10
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        ecc_en,
    input  logic                                        req_valid,
    output logic                                        req_ready,
    input  logic                                        req_write,
    input  logic [ADDR_W-1:0]                           req_addr,
    input  logic [DATA_W-1:0]                           req_wdata,
    input  logic [DATA_W/8-1:0]                         req_be,
    output logic                                        rsp_valid,
    output logic                                        rsp_is_write,
    output logic [DATA_W-1:0]                           rsp_rdata,
    output logic                                        rsp_err_corr,
    output logic                                        rsp_err_uncorr,
    output logic                                        rsp_err_addr,
    output logic                                        ram_en,
    output logic                                        ram_we,
    output logic [ADDR_W-1:0]                           ram_addr,
    output logic [DATA_W+ham_bits(DATA_W+ADDR_W):0]     ram_wdata,
    input  logic [DATA_W+ham_bits(DATA_W+ADDR_W):0]     ram_rdata
);
    localparam int CHK_W = ham_bits(DATA_W + ADDR_W) + 1;

    logic [DATA_W-1:0] enc_data, dec_fix;
    logic [ADDR_W-1:0] enc_addr, cur_addr;
    logic [CHK_W-1:0]  enc_chk;
    logic              enc_on;
    logic              dec_corr, dec_uncorr, dec_aerr;

    ecc_chk_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_enc (
        .data (enc_data),
        .addr (enc_addr),
        .chk  (enc_chk)
    );

    ecc_syn_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .rd_data   (ram_rdata[DATA_W-1:0]),
        .rd_chk    (ram_rdata[DATA_W +: CHK_W]),
        .rd_addr   (cur_addr),
        .fix_data  (dec_fix),
        .is_corr   (dec_corr),
        .is_uncorr (dec_uncorr),
        .is_aerr   (dec_aerr)
    );

    ecc_rmw_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ecc_en         (ecc_en),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_be         (req_be),
        .raw_data       (ram_rdata[DATA_W-1:0]),
        .dec_fix        (dec_fix),
        .dec_corr       (dec_corr),
        .dec_uncorr     (dec_uncorr),
        .dec_aerr       (dec_aerr),
        .cur_addr       (cur_addr),
        .ram_en         (ram_en),
        .ram_we         (ram_we),
        .ram_addr       (ram_addr),
        .enc_data       (enc_data),
        .enc_addr       (enc_addr),
        .enc_on         (enc_on),
        .rsp_valid      (rsp_valid),
        .rsp_is_write   (rsp_is_write),
        .rsp_rdata      (rsp_rdata),
        .rsp_err_corr   (rsp_err_corr),
        .rsp_err_uncorr (rsp_err_uncorr),
        .rsp_err_addr   (rsp_err_addr)
    );

    // Stored word: check field zeroed in bypass mode
    assign ram_wdata = {(enc_on ? enc_chk : '0), enc_data};

    // R11: responses are single-cycle pulses
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: never more than one error class per response
    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_err_corr, rsp_err_uncorr, rsp_err_addr}));

    // R3: a read alters at most one bit of the RAM data
    a_r3_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_write) |-> ($countones(rsp_rdata ^ ram_rdata[DATA_W-1:0]) <= 1));

    // R6: flagged reads hand back the raw RAM data
    a_r6_raw_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_write && (rsp_err_uncorr || rsp_err_addr))
            |-> (rsp_rdata == ram_rdata[DATA_W-1:0]));

endmodule

// File: tb/tb_ecc_mem_guard.sv
// Bench for ecc_mem_guard with a 16-word RAM model that can flip stored
// bits and return a neighbouring row to emulate address faults.
module tb_ecc_mem_guard;
    localparam int DW = 128;
    localparam int AW = 4;
    localparam int WW = DW + 9;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ecc_en = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [15:0]   req_be = '0;
    logic          rsp_valid, rsp_is_write, rsp_err_corr, rsp_err_uncorr, rsp_err_addr;
    logic [DW-1:0] rsp_rdata;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [WW-1:0] ram_wdata, ram_rdata;

    ecc_mem_guard #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_is_write(rsp_is_write), .rsp_rdata(rsp_rdata),
        .rsp_err_corr(rsp_err_corr), .rsp_err_uncorr(rsp_err_uncorr),
        .rsp_err_addr(rsp_err_addr),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always #10 clk = ~clk;

    // RAM model with fault injection
    logic [WW-1:0] mem [NW];
    logic [WW-1:0] rd_q;
    logic [AW-1:0] fault = '0;
    logic          inj_go = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [WW-1:0] inj_mask = '0;
    logic [8:0]    last_chk = '0;
    assign ram_rdata = rd_q;

    always @(posedge clk) begin
        if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        if (ram_en) begin
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                last_chk      <= ram_wdata[WW-1:DW];
            end else begin
                rd_q <= mem[ram_addr ^ fault];
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;
    logic [DW-1:0] gold [NW];

    // Response capture
    logic [3:0]    r_lat;
    logic [3:0]    r_flags;
    logic [DW-1:0] r_data;
    logic          r_busy, r_pulse_ok;

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            finish_up();
        end
    end

    task automatic check(input string tag, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return {32'(a * 32'h9E3779B9 + s), 32'(a * 32'h85EBCA6B ^ s),
                32'(~(a * 32'hC2B2AE35) + s * 7), 32'(a * 32'h27D4EB2F ^ (s << 5))};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [15:0] be);
        logic [DW-1:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    task automatic inject(input int a, input logic [WW-1:0] m);
        @(negedge clk);
        inj_addr = AW'(a);
        inj_mask = m;
        inj_go   = 1'b1;
        @(negedge clk);
        inj_go   = 1'b0;
    endtask

    task automatic do_req(input logic w, input int a, input logic [DW-1:0] d, input logic [15:0] be);
        logic got;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 4'd1; r_busy = 1'b0; got = 1'b0;
        r_flags = 4'hF; r_data = '0;
        for (int n = 0; n < 8 && !got; n++) begin
            if (rsp_valid) begin
                got = 1'b1;
                r_flags = {rsp_is_write, rsp_err_corr, rsp_err_uncorr, rsp_err_addr};
                r_data  = rsp_rdata;
            end else begin
                if (!req_ready) r_busy = 1'b1;
                @(negedge clk);
                r_lat = r_lat + 4'd1;
            end
        end
        @(negedge clk);
        r_pulse_ok = got && !rsp_valid;
    endtask

    function automatic logic [135:0] pk(input logic [3:0] l, input logic [3:0] f, input logic [DW-1:0] d);
        return {l, f, d};
    endfunction

    initial begin
        logic [WW-1:0] m;
        logic [DW-1:0] nd, ex;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 136'(req_ready), 136'(1));
        check("R1 rsp_valid in reset", 136'(rsp_valid), 136'(0));
        check("R1 ram_en in reset", 136'(ram_en), 136'(0));
        rst_n = 1'b1;

        // R2: full writes and clean reads of every word
        for (int a = 0; a < NW; a++) begin
            gold[a] = pat(a, 1);
            do_req(1'b1, a, gold[a], 16'hFFFF);
            check("R2 full write response", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b1000, '0));
        end
        for (int a = 0; a < NW; a++) begin
            do_req(1'b0, a, '0, 16'h0);
            check("R2 clean read", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0000, gold[a]));
            check("R11 single pulse", 136'(r_pulse_ok), 136'(1));
        end

        // R3: every data bit position corrected
        for (int b = 0; b < DW; b++) begin
            m = WW'(1) << b;
            inject(b % NW, m);
            do_req(1'b0, b % NW, '0, 16'h0);
            check("R3 data bit corrected", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0100, gold[b % NW]));
            inject(b % NW, m);
        end

        // R4: every check bit position
        for (int b = DW; b < WW; b++) begin
            m = WW'(1) << b;
            inject(b % NW, m);
            do_req(1'b0, b % NW, '0, 16'h0);
            check("R4 check bit fault", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0100, gold[b % NW]));
            inject(b % NW, m);
        end

        // R5: one-bit address slips
        for (int b = 0; b < AW; b++) begin
            fault = AW'(1 << b);
            do_req(1'b0, 5, '0, 16'h0);
            check("R5 address error", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0001, gold[5 ^ (1 << b)]));
            fault = '0;
        end

        // R6: paired faults
        for (int i = 0; i < 16; i++) begin
            int p, q;
            p = (i * 9) % WW;
            q = (p + 40 + i) % WW;
            m = (WW'(1) << p) | (WW'(1) << q);
            inject(i, m);
            do_req(1'b0, i, '0, 16'h0);
            ex = gold[i] ^ m[DW-1:0];
            check("R6 double fault raw", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0010, ex));
            inject(i, m);
        end

        // R7: partial writes, one lane each, then a mixed mask
        for (int i = 0; i < 17; i++) begin
            logic [15:0] be;
            be = (i < 16) ? 16'(1 << i) : 16'h5A3C;
            nd = pat(i, 77);
            gold[i % NW] = merge(gold[i % NW], nd, be);
            do_req(1'b1, i % NW, nd, be);
            check("R7 partial write response", pk(r_lat, r_flags, r_data), pk(4'd2, 4'b1000, '0));
            check("R11 busy during merge", 136'(r_busy), 136'(1));
            do_req(1'b0, i % NW, '0, 16'h0);
            check("R7 merged readback", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0000, gold[i % NW]));
        end

        // R9: merge over a corrected word
        inject(3, WW'(1) << 77);
        nd = pat(3, 99);
        gold[3] = merge(gold[3], nd, 16'h00FF);
        do_req(1'b1, 3, nd, 16'h00FF);
        check("R9 corrected merge response", pk(r_lat, r_flags, r_data), pk(4'd2, 4'b1100, '0));
        do_req(1'b0, 3, '0, 16'h0);
        check("R9 corrected merge readback", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0000, gold[3]));

        // R8: merge aborted over an uncorrectable word
        m = (WW'(1) << 10) | (WW'(1) << 100);
        inject(4, m);
        do_req(1'b1, 4, pat(4, 55), 16'h0001);
        check("R8 abort response", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b1010, '0));
        do_req(1'b0, 4, '0, 16'h0);
        check("R8 word unchanged", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0010, gold[4] ^ m[DW-1:0]));
        inject(4, m);

        // R10: bypass mode
        ecc_en = 1'b0;
        gold[7] = pat(7, 3);
        do_req(1'b1, 7, gold[7], 16'hFFFF);
        check("R10 zero check field", 136'(last_chk), 136'(0));
        do_req(1'b0, 7, '0, 16'h0);
        check("R10 bypass read", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0000, gold[7]));
        inject(7, WW'(1) << 33);
        do_req(1'b0, 7, '0, 16'h0);
        check("R10 bypass no correction", pk(r_lat, r_flags, r_data),
              pk(4'd1, 4'b0000, gold[7] ^ (DW'(1) << 33)));
        inject(7, WW'(1) << 33);
        ecc_en = 1'b1;
        do_req(1'b1, 7, gold[7], 16'hFFFF);
        do_req(1'b0, 7, '0, 16'h0);
        check("R2 re-protected read", pk(r_lat, r_flags, r_data), pk(4'd1, 4'b0000, gold[7]));

        done = 1'b1;
        finish_up();
    end

endmodule